// File: doc/BRIEF.md
# Pad-Ring Boundary Scan Register

This block sits between a chip core and its I/O pads and gives a test controller serial access to every pad signal. Each pad owns four scan cells. Two cells sit on the outbound path: the value the core wants on the pad and its output enable. Two cells sit on the inbound path: the level seen at the pad and the level handed to the core. A serial chain runs from `tdi` to `tdo`. Three strobes, generated by an external TAP controller, make the chain load live values, shift by one bit, or copy its contents into a parallel holding stage.

A decoded instruction code picks the mode. In the observe mode (code 2, also used to preload), the core and the pads stay wired straight through. The chain can only capture and report the live values in this mode. In the drive mode (code 0), both the outbound and the inbound links are cut. The holding stage then drives the pads, their enables and the core inputs. The chain and the holding stage both keep their contents across scans. A pattern left in the holding stage therefore takes effect as soon as the drive mode is entered.

Top module: `pad_bscan_chain`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, the chain and the holding stage clear to zero. `tdo` reads 0 after the following falling edge, and the pad paths are transparent.
- R2: With any instruction code other than 0 (code 2 being the observe/preload mode), `pad_out` equals `core_out`, `pad_oe` equals `core_oe` and `core_in` equals `pad_in`, bit for bit.
- R3: In the observe mode, data shifted in and copied to the holding stage has no effect on `pad_out`, `pad_oe` or `core_in`.
- R4: On a rising edge with `capture_en` high, chain bit 4p+0 loads `core_out[p]`, bit 4p+1 loads `core_oe[p]`, bit 4p+2 loads `pad_in[p]` and bit 4p+3 loads the value currently on `core_in[p]`.
- R5: On a rising edge with `shift_en` high and `capture_en` low, `tdi` enters chain bit 4N-1 and every bit moves one place toward bit 0. `tdo` presents chain bit 0, registered on the falling edge.
- R6: When `capture_en` and `shift_en` are both high, the capture takes place and the shift does not.
- R7: The holding stage copies the whole chain on a rising edge with `update_en` high, and holds its value on every other edge. This includes edges during shifting.
- R8: With instruction code 0, `pad_out[p]` is holding bit 4p+0, `pad_oe[p]` is holding bit 4p+1 and `core_in[p]` is holding bit 4p+3. These outputs are independent of `core_out`, `core_oe` and `pad_in`.
- R9: Chain and holding contents survive mode changes. Entering code 0 without a new update drives the previously held pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| instr | input | CODE_W | Decoded instruction code (0 drive, 2 observe) |
| capture_en | input | 1 | Load live values into the chain |
| shift_en | input | 1 | Shift the chain by one bit |
| update_en | input | 1 | Copy the chain into the holding stage |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| core_out | input | NUM_PADS | Core's intended pad levels |
| core_oe | input | NUM_PADS | Core's intended pad output enables |
| pad_in | input | NUM_PADS | Levels received from the pads |
| pad_out | output | NUM_PADS | Levels driven to the pads |
| pad_oe | output | NUM_PADS | Output enables driven to the pads |
| core_in | output | NUM_PADS | Levels handed to the core |

## Verification
A wrong chain bit never shows directly at the pads. It appears on `tdo` only after the bits below it have been shifted out, which can take up to 4N shift cycles. For that reason, every shift cycle's `tdo` is compared with a bench model. A corrupted holding stage shows on the pad-side outputs on the first cycle of drive mode, and stays invisible in the observe mode. Each cycle's outputs are therefore compared in both modes, including re-entry into drive mode after a stale load. A capture of the wrong source is caught one full unload later.

// File: rtl/pbs_pkg.sv
// Shared constants for the pad-ring boundary scan register.
// Assumes four cells per pad in the fixed order below.
package pbs_pkg;
    localparam int CELLS_PER_PAD = 4;
    localparam int CELL_COUT     = 0;
    localparam int CELL_COE      = 1;
    localparam int CELL_PIN      = 2;
    localparam int CELL_CIN      = 3;
    localparam int CODE_DRIVE    = 0;
    localparam int CODE_OBSERVE  = 2;
endpackage

// File: rtl/pbs_shift_stage.sv
// Serial chain of the scan register: parallel capture, shift toward bit 0,
// falling-edge registered serial output. Assumes LEN >= 2.
module pbs_shift_stage #(
    parameter int LEN = 16
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           capture_en,
    input  logic           shift_en,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] sr_q,
    output logic           tdo
);
    // Chain register: capture wins over shift.
    always_ff @(posedge tck) begin
        if (!trst_n)         sr_q <= '0;
        else if (capture_en) sr_q <= cap_vec;
        else if (shift_en)   sr_q <= {tdi, sr_q[LEN-1:1]};
    end

    // Serial output retimed to the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) tdo <= 1'b0;
        else         tdo <= sr_q[0];
    end

    // R5: shifted bit enters at the far end
    a_r5_shift_entry: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !capture_en) |=> (sr_q[LEN-1] == $past(tdi)));

    // R4, R6: capture loads the live vector even when shift is high
    a_r6_capture_wins: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en |=> (sr_q == $past(cap_vec)));
endmodule

// File: rtl/pbs_update_stage.sv
// Parallel holding stage: copies the chain on the update strobe only.
// Assumes the strobe is synchronous to tck.
module pbs_update_stage #(
    parameter int LEN = 16
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           update_en,
    input  logic [LEN-1:0] sr_d,
    output logic [LEN-1:0] upd_q
);
    // Holding register load.
    always_ff @(posedge tck) begin
        if (!trst_n)        upd_q <= '0;
        else if (update_en) upd_q <= sr_d;
    end

    // R7: no change without the update strobe
    a_r7_hold_stable: assert property (@(posedge tck) disable iff (!trst_n)
        !update_en |=> $stable(upd_q));
endmodule

// File: rtl/pbs_pad_mux.sv
// Per-pad path selection and capture vector assembly.
// Assumes the holding vector uses the package cell order.
module pbs_pad_mux
    import pbs_pkg::*;
#(
    parameter int NUM_PADS = 4,
    localparam int LEN = NUM_PADS * CELLS_PER_PAD
) (
    input  logic                drive_mode,
    input  logic [LEN-1:0]      upd_q,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] core_in,
    output logic [LEN-1:0]      cap_vec
);
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        localparam int BASE = p * CELLS_PER_PAD;
        // Select live or held value for each path.
        always_comb begin
            pad_out[p] = drive_mode ? upd_q[BASE+CELL_COUT] : core_out[p];
            pad_oe[p]  = drive_mode ? upd_q[BASE+CELL_COE]  : core_oe[p];
            core_in[p] = drive_mode ? upd_q[BASE+CELL_CIN]  : pad_in[p];
        end
        // Assemble the four observed values of this pad.
        always_comb begin
            cap_vec[BASE+CELL_COUT] = core_out[p];
            cap_vec[BASE+CELL_COE]  = core_oe[p];
            cap_vec[BASE+CELL_PIN]  = pad_in[p];
            cap_vec[BASE+CELL_CIN]  = core_in[p];
        end
    end
endmodule

// File: rtl/pad_bscan_chain.sv
// Top of the pad-ring boundary scan register: decodes the mode and joins
// the chain, the holding stage and the per-pad selectors.
// Assumes strobes come from an external TAP controller on tck.
module pad_bscan_chain
    import pbs_pkg::*;
#(
    parameter int NUM_PADS = 4,
    parameter int CODE_W   = 4,
    localparam int LEN = NUM_PADS * CELLS_PER_PAD
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic [CODE_W-1:0]   instr,
    input  logic                capture_en,
    input  logic                shift_en,
    input  logic                update_en,
    input  logic                tdi,
    output logic                tdo,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] core_in
);
    logic           drive_mode;
    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] upd_q;
    logic [LEN-1:0] cap_vec;

    // Mode decode: only the drive code cuts the core-pad links.
    always_comb drive_mode = (instr == CODE_W'(CODE_DRIVE));

    pbs_shift_stage #(.LEN(LEN)) u_shift (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en),
        .shift_en(shift_en), .tdi(tdi), .cap_vec(cap_vec),
        .sr_q(sr_q), .tdo(tdo)
    );

    pbs_update_stage #(.LEN(LEN)) u_update (
        .tck(tck), .trst_n(trst_n), .update_en(update_en),
        .sr_d(sr_q), .upd_q(upd_q)
    );

    pbs_pad_mux #(.NUM_PADS(NUM_PADS)) u_mux (
        .drive_mode(drive_mode), .upd_q(upd_q), .core_out(core_out),
        .core_oe(core_oe), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .core_in(core_in), .cap_vec(cap_vec)
    );

    // R2: non-drive codes keep both directions transparent
    a_r2_transparent: assert property (@(posedge tck) disable iff (!trst_n)
        (instr != CODE_W'(CODE_DRIVE)) |->
        (pad_out == core_out && pad_oe == core_oe && core_in == pad_in));

    // R8: drive mode ties pad outputs to the held pattern
    a_r8_drive_pads: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == CODE_W'(CODE_DRIVE)) |->
        (pad_out[0] == upd_q[CELL_COUT] && pad_oe[0] == upd_q[CELL_COE]
         && core_in[0] == upd_q[CELL_CIN]));
endmodule

// File: tb/pad_bscan_chain_tb.sv
`timescale 1ns/1ps
module pad_bscan_chain_tb;
    localparam int N = 4;
    localparam int L = N * 4;
    localparam int CW = 4;

    logic          tck = 1'b0;
    logic          trst_n;
    logic [CW-1:0] instr;
    logic          capture_en, shift_en, update_en, tdi;
    logic          tdo;
    logic [N-1:0]  core_out, core_oe, pad_in;
    logic [N-1:0]  pad_out, pad_oe, core_in;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [L-1:0] m_sr, m_upd;
    logic [N-1:0] e_po, e_poe, e_ci;

    always #2.5 tck = ~tck;

    pad_bscan_chain #(.NUM_PADS(N), .CODE_W(CW)) u_dut (
        .tck(tck), .trst_n(trst_n), .instr(instr), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
    );

    task automatic calc_exp();
        for (int p = 0; p < N; p++) begin
            if (instr == 0) begin
                e_po[p] = m_upd[4*p]; e_poe[p] = m_upd[4*p+1]; e_ci[p] = m_upd[4*p+3];
            end else begin
                e_po[p] = core_out[p]; e_poe[p] = core_oe[p]; e_ci[p] = pad_in[p];
            end
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outs();
        calc_exp();
        chk(instr == 0 ? "R8 pads" : "R2 pads",
            16'({pad_out, pad_oe, core_in}), 16'({e_po, e_poe, e_ci}));
    endtask

    // One tck cycle with given strobes; model advances, then tdo and outputs are checked.
    task automatic tick(input logic cap, input logic sh, input logic up,
                        input logic b, input string tag);
        logic [L-1:0] cv, old;
        capture_en = cap; shift_en = sh; update_en = up; tdi = b;
        calc_exp();
        for (int p = 0; p < N; p++) begin
            cv[4*p] = core_out[p]; cv[4*p+1] = core_oe[p];
            cv[4*p+2] = pad_in[p]; cv[4*p+3] = e_ci[p];
        end
        @(posedge tck); #1;
        old = m_sr;
        if (!trst_n) begin
            m_sr = '0; m_upd = '0;
        end else begin
            if (cap) m_sr = cv;
            else if (sh) m_sr = {b, m_sr[L-1:1]};
            if (up) m_upd = old;
        end
        @(negedge tck); #1;
        chk(tag, 16'(tdo), 16'(m_sr[0]));
        check_outs();
        capture_en = 0; shift_en = 0; update_en = 0;
    endtask

    task automatic shift_word(input logic [L-1:0] w, input string tag);
        for (int i = 0; i < L; i++) tick(0, 1, 0, w[i], tag);
    endtask

    task automatic rand_inputs();
        core_out = N'($urandom); core_oe = N'($urandom); pad_in = N'($urandom);
    endtask

    initial begin
        #(5 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] h_po, h_poe, h_ci;
        logic [L-1:0] pat;
        void'($urandom(32'h5eed_1234));
        trst_n = 0; instr = 2; capture_en = 0; shift_en = 0; update_en = 0; tdi = 0;
        core_out = 4'ha; core_oe = 4'h5; pad_in = 4'hc;
        m_sr = 'x; m_upd = 'x;
        tick(0, 0, 0, 0, "R1 reset tdo");
        tick(0, 0, 0, 0, "R1 reset tdo");
        chk("R1 transparent after reset", 16'({pad_out, pad_oe, core_in}),
            16'({core_out, core_oe, pad_in}));
        trst_n = 1;

        // R3: observe mode, load all ones and update: pads unaffected
        shift_word('1, "R5 shift");
        tick(0, 0, 1, 0, "R3 update");
        core_out = 4'h0; core_oe = 4'h0; pad_in = 4'h0;
        #0; chk("R3 no effect", 16'({pad_out, pad_oe, core_in}), 16'h0);

        // R4: capture live values and unload them
        core_out = 4'b1001; core_oe = 4'b0110; pad_in = 4'b0011;
        tick(1, 0, 0, 0, "R4 capture");
        shift_word(16'h0000, "R4 unload");

        // R6: capture and shift together
        rand_inputs();
        tick(1, 1, 0, 1, "R6 capture priority");
        shift_word(16'h0000, "R6 unload");

        // R8/R7: load a pattern, drive it, check stability while shifting
        pat = 16'hb6d3;
        shift_word(pat, "R5 load");
        tick(0, 0, 1, 0, "R7 update");
        instr = 0; rand_inputs();
        #0; check_outs();
        h_po = pad_out; h_poe = pad_oe; h_ci = core_in;
        chk("R8 drive value", 16'({pad_out, pad_oe, core_in}),
            16'({pat[12], pat[8], pat[4], pat[0], pat[13], pat[9], pat[5], pat[1],
                 pat[15], pat[11], pat[7], pat[3]}));
        shift_word(16'h1234, "R7 shift in drive");
        rand_inputs();
        #0; chk("R7 held while shifting", 16'({pad_out, pad_oe, core_in}),
                16'({h_po, h_poe, h_ci}));

        // R9: leave drive mode and return without update: old pattern reappears
        instr = 2; tick(0, 0, 0, 0, "R9 observe");
        instr = 0; rand_inputs();
        #0; chk("R9 stale pattern", 16'({pad_out, pad_oe, core_in}),
                16'({h_po, h_poe, h_ci}));
        tick(0, 0, 1, 0, "R9 new update");

        // Random scans across all codes
        for (int it = 0; it < 60; it++) begin
            instr = CW'($urandom_range(0, 3));
            rand_inputs();
            if ($urandom_range(0, 1) == 1) tick(1, $urandom_range(0, 1) == 1, 0, 0, "R4 rand capture");
            shift_word(L'($urandom), "R5 rand shift");
            if ($urandom_range(0, 2) != 0) tick(0, 0, 1, 0, "R7 rand update");
            rand_inputs();
            tick(0, 0, 0, 0, "R2 rand idle");
        end

        // R1: reset mid-run clears everything
        instr = 0; trst_n = 0;
        tick(0, 0, 0, 0, "R1 mid reset");
        trst_n = 1; instr = 2;
        tick(0, 0, 0, 0, "R1 after reset");
        instr = 0; #0; chk("R1 held cleared", 16'({pad_out, pad_oe, core_in}), 16'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule